// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block guards a single shared storage word that several requesters may try to write in the same clock cycle. Each requester offers a valid bit and a data word. A policy input selects how the offered words are merged into the one value stored at the next rising edge. The policies are:

- keep an arbitrary value;
- store a reserved marker when writers clash;
- accept only unanimous writes;
- take a pseudo-random writer;
- let the lowest-numbered writer win;
- keep the unsigned largest or smallest value;
- fold the values by sum, bitwise AND or bitwise XOR.

The stored word, a write strobe and a clash flag are all registered outputs. They show the outcome of the requests that were sampled at the previous edge. Requester i places its data at bits [i*DW +: DW] of the packed data input. The number of requesters (NREQ), the word width (DW) and the clash marker (COLL_CODE, all ones by default) are parameters.

Top module: `cw_resolver`

## Requirements
- R1: While rst_n is low at a rising edge, the edge leaves word_o = 0, wr_en_o = 0 and collide_o = 0, whatever the requests are.
- R2: After an edge with no valid requester, wr_en_o is 0, collide_o is 0 and word_o keeps its previous value.
- R3: With exactly one valid requester, every policy code 0..9 stores that requester's data unchanged, with wr_en_o = 1 and collide_o = 0.
- R4: After an edge with two or more valid requesters, collide_o is 1, in every policy.
- R5: Policy code 4 (lowest index wins) stores the data of the lowest-numbered valid requester. Unused codes 10..15 behave the same way.
- R6: Policy code 1 (clash marker) stores COLL_CODE whenever two or more requesters are valid.
- R7: Policy code 2 (unanimous) stores the common value when all valid requesters offer equal data. When they differ, wr_en_o is 0 and word_o is unchanged.
- R8: Policy code 3 (random) stores the data of one of the valid requesters. The choice comes from a free-running LFSR, and the internal pick always points at a requester whose valid bit is set.
- R9: Policy codes 5 and 6 store the unsigned maximum and the unsigned minimum of the offered values.
- R10: Policy code 7 stores the sum of the offered values, modulo 2^DW.
- R11: Policy code 8 stores the bitwise AND and policy code 9 stores the bitwise XOR of the offered values.
- R12: Policy code 0 (unspecified) raises wr_en_o on a clash. The stored data is then not specified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 4 | Merge policy code |
| req_valid_i | input | NREQ | One write-request bit per requester |
| req_data_i | input | NREQ*DW | Packed request data, requester i at [i*DW +: DW] |
| word_o | output | DW | Stored shared word |
| wr_en_o | output | 1 | A value was stored at the last edge |
| collide_o | output | 1 | Two or more requesters were valid at the last edge |

## Verification
The bench drives values that separate signed from unsigned ordering, such as 0x0F against 0x80, so a signed comparator would report the wrong maximum. It uses sums that overflow the word, which a design that saturates or keeps a carry would get wrong. It uses unanimous-policy patterns where one lane differs; a design that ignores that lane would store a value instead of holding the word. Priority patterns put the winner at lanes other than 0, so a design that picks the highest index or always picks lane 0 shows up. Random-policy patterns leave invalid lanes carrying distinct data, so any pick of an idle requester lands on a value that no valid lane offered.

// File: rtl/cwr_pkg.sv
// Package: shared policy codes for the concurrent-write resolver.
// Assumes a 4-bit policy input; codes not listed fall back to lowest-index-wins.
package cwr_pkg;
    typedef enum logic [3:0] {
        CW_UNDEF    = 4'd0,
        CW_DETECT   = 4'd1,
        CW_COMMON   = 4'd2,
        CW_RANDOM   = 4'd3,
        CW_PRIORITY = 4'd4,
        CW_MAX      = 4'd5,
        CW_MIN      = 4'd6,
        CW_SUM      = 4'd7,
        CW_AND      = 4'd8,
        CW_XOR      = 4'd9
    } cw_mode_e;
endpackage

// File: rtl/cwr_fold.sv
// Module: combinational fold of all valid request words.
// It yields the lowest-index value, the highest-index value, the unsigned
// max and min, the wrapping sum, AND, XOR, an all-equal flag and the
// number of active requesters.
// Assumes the packed data holds requester i at [i*DW +: DW].
module cwr_fold #(
    parameter int NREQ = 4,
    parameter int DW   = 8,
    localparam int CW  = $clog2(NREQ + 1)
) (
    input  logic [NREQ-1:0]    valid_i,
    input  logic [NREQ*DW-1:0] data_i,
    output logic [DW-1:0]      first_o,
    output logic [DW-1:0]      last_o,
    output logic [DW-1:0]      max_o,
    output logic [DW-1:0]      min_o,
    output logic [DW-1:0]      sum_o,
    output logic [DW-1:0]      and_o,
    output logic [DW-1:0]      xor_o,
    output logic               same_o,
    output logic [CW-1:0]      count_o
);
    // Walk all requesters once and accumulate every fold result.
    always_comb begin
        logic found;
        found   = 1'b0;
        first_o = '0;
        last_o  = '0;
        max_o   = '0;
        min_o   = '1;
        sum_o   = '0;
        and_o   = '1;
        xor_o   = '0;
        count_o = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (valid_i[i]) begin
                if (!found) first_o = data_i[i*DW +: DW];
                found   = 1'b1;
                last_o  = data_i[i*DW +: DW];
                if (data_i[i*DW +: DW] > max_o) max_o = data_i[i*DW +: DW];
                if (data_i[i*DW +: DW] < min_o) min_o = data_i[i*DW +: DW];
                sum_o   = sum_o + data_i[i*DW +: DW];
                and_o   = and_o & data_i[i*DW +: DW];
                xor_o   = xor_o ^ data_i[i*DW +: DW];
                count_o = count_o + CW'(1);
            end
        end
    end

    // Flag agreement: every valid word equals the lowest-index valid word.
    always_comb begin
        same_o = 1'b1;
        for (int i = 0; i < NREQ; i++) begin
            if (valid_i[i] && (data_i[i*DW +: DW] != first_o)) same_o = 1'b0;
        end
    end
endmodule

// File: rtl/cwr_rand_pick.sv
// Module: pseudo-random requester pick.
// A Galois LFSR advances on every clock. Its value modulo NREQ gives a
// starting lane, and the first valid lane at or after that start (wrapping)
// is picked. If no lane is valid the pick is lane 0 and pick_ok_o is low.
// Assumes TAPS is a maximal-length mask for LW bits and SEED is nonzero.
module cwr_rand_pick #(
    parameter int          NREQ = 4,
    parameter int          DW   = 8,
    parameter int          LW   = 16,
    parameter logic [15:0] TAPS = 16'hB400,
    parameter logic [15:0] SEED = 16'hACE1,
    localparam int         IW   = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    valid_i,
    input  logic [NREQ*DW-1:0] data_i,
    output logic [IW-1:0]      pick_idx_o,
    output logic [DW-1:0]      pick_data_o,
    output logic               pick_ok_o
);
    logic [LW-1:0] lfsr_q;
    int            start;

    // Step the LFSR every cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LW'(SEED);
        else        lfsr_q <= {1'b0, lfsr_q[LW-1:1]} ^ (lfsr_q[0] ? LW'(TAPS) : '0);
    end

    // Rotate from the random start and take the nearest valid lane.
    always_comb begin
        int idx;
        start      = int'(lfsr_q % LW'(NREQ));
        pick_idx_o = '0;
        pick_ok_o  = 1'b0;
        for (int k = NREQ - 1; k >= 0; k--) begin
            idx = (start + k) % NREQ;
            if (valid_i[idx]) begin
                pick_idx_o = IW'(idx);
                pick_ok_o  = 1'b1;
            end
        end
    end

    // Route the picked lane's data out.
    assign pick_data_o = data_i[pick_idx_o*DW +: DW];
endmodule

// File: rtl/cw_resolver.sv
// Module: concurrent-write resolver for one shared word (top).
// Merges same-cycle write requests under a selectable policy and stores
// the result at the rising edge. word_o, wr_en_o and collide_o are
// registered and describe the requests sampled at the previous edge.
// Assumes mode_i is held stable around the sampling edge.
module cw_resolver #(
    parameter int          NREQ      = 4,
    parameter int          DW        = 8,
    parameter logic [63:0] COLL_CODE = '1,
    localparam int         CW        = $clog2(NREQ + 1),
    localparam int         IW        = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         mode_i,
    input  logic [NREQ-1:0]    req_valid_i,
    input  logic [NREQ*DW-1:0] req_data_i,
    output logic [DW-1:0]      word_o,
    output logic               wr_en_o,
    output logic               collide_o
);
    import cwr_pkg::*;

    logic [DW-1:0] f_first, f_last, f_max, f_min, f_sum, f_and, f_xor;
    logic          f_same;
    logic [CW-1:0] f_count;
    logic [IW-1:0] rnd_idx;
    logic [DW-1:0] rnd_data;
    logic          rnd_ok;
    logic [DW-1:0] cand;
    logic          multi, commit;
    cw_mode_e      mode;

    cwr_fold #(.NREQ(NREQ), .DW(DW)) u_fold (
        .valid_i (req_valid_i),
        .data_i  (req_data_i),
        .first_o (f_first),
        .last_o  (f_last),
        .max_o   (f_max),
        .min_o   (f_min),
        .sum_o   (f_sum),
        .and_o   (f_and),
        .xor_o   (f_xor),
        .same_o  (f_same),
        .count_o (f_count)
    );

    cwr_rand_pick #(.NREQ(NREQ), .DW(DW)) u_rand (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (req_valid_i),
        .data_i      (req_data_i),
        .pick_idx_o  (rnd_idx),
        .pick_data_o (rnd_data),
        .pick_ok_o   (rnd_ok)
    );

    assign mode  = cw_mode_e'(mode_i);
    assign multi = (f_count > CW'(1));

    // Choose the candidate word for the selected policy.
    always_comb begin
        case (mode)
            CW_UNDEF:  cand = f_last;
            CW_DETECT: cand = multi ? COLL_CODE[DW-1:0] : f_first;
            CW_COMMON: cand = f_first;
            CW_RANDOM: cand = rnd_ok ? rnd_data : f_first;
            CW_MAX:    cand = f_max;
            CW_MIN:    cand = f_min;
            CW_SUM:    cand = f_sum;
            CW_AND:    cand = f_and;
            CW_XOR:    cand = f_xor;
            default:   cand = f_first;
        endcase
    end

    // Store only when someone writes and a unanimous check (if any) holds.
    assign commit = (|req_valid_i) && !((mode == CW_COMMON) && !f_same);

    // Register the stored word, the write strobe and the clash flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o    <= '0;
            wr_en_o   <= 1'b0;
            collide_o <= 1'b0;
        end else begin
            wr_en_o   <= commit;
            collide_o <= multi;
            if (commit) word_o <= cand;
        end
    end
endmodule

// File: rtl/cw_resolver_chk.sv
// Module: property checker for the resolver, attached by bind.
// Assumes it sees the top's ports and the internal random pick index.
module cw_resolver_chk #(
    parameter int          NREQ      = 4,
    parameter int          DW        = 8,
    parameter logic [63:0] COLL_CODE = '1,
    localparam int         IW        = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [3:0]      mode_i,
    input logic [NREQ-1:0] req_valid_i,
    input logic [DW-1:0]   word_o,
    input logic            wr_en_o,
    input logic            collide_o,
    input logic [IW-1:0]   rnd_idx
);
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i == '0) |=> (!wr_en_o && !collide_o && $stable(word_o))); // R2
    AST_SINGLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_valid_i) == 1) |=> (wr_en_o && !collide_o)); // R3
    AST_MULTI_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(req_valid_i) > 1) |=> collide_o); // R4
    AST_DETECT_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 4'd1) && ($countones(req_valid_i) > 1)) |=> (word_o == COLL_CODE[DW-1:0])); // R6
    AST_RANDOM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 4'd3) && (req_valid_i != '0)) |-> req_valid_i[rnd_idx]); // R8
    AST_UNDEF_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 4'd0) && (req_valid_i != '0)) |=> wr_en_o); // R12
endmodule

bind cw_resolver cw_resolver_chk #(.NREQ(NREQ), .DW(DW), .COLL_CODE(COLL_CODE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .req_valid_i (req_valid_i),
    .word_o      (word_o),
    .wr_en_o     (wr_en_o),
    .collide_o   (collide_o),
    .rnd_idx     (rnd_idx)
);

// File: tb/cw_resolver_test.sv
// Bench: scoreboard for the resolver. A driver task applies one request set
// per cycle and queues the expected outcome; a monitor pops and compares.
module cw_resolver_test;
    localparam int NREQ = 4;
    localparam int DW   = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [3:0]         mode = 4'd0;
    logic [NREQ-1:0]    valid = '0;
    logic [NREQ*DW-1:0] data = '0;
    logic [DW-1:0]      word_o;
    logic               wr_en_o, collide_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct {
        bit                 we;
        bit                 col;
        int                 dmode;   // 0 skip data, 1 exact, 2 any valid lane
        logic [DW-1:0]      word;
        logic [NREQ*DW-1:0] offered;
        logic [NREQ-1:0]    offv;
        string              tag;
    } exp_t;

    exp_t          q[$];
    logic [DW-1:0] model_word = '0;
    bit            known = 1'b1;

    cw_resolver #(.NREQ(NREQ), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_valid_i(valid),
        .req_data_i(data), .word_o(word_o), .wr_en_o(wr_en_o), .collide_o(collide_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [NREQ*DW-1:0] pk(input logic [DW-1:0] a, b, c, d);
        return {d, c, b, a};
    endfunction

    // Driver: compute the expected outcome from the requirements, apply, queue.
    task automatic drive(input logic [3:0] m, input logic [NREQ-1:0] v,
                         input logic [NREQ*DW-1:0] d, input string tag);
        exp_t e;
        int   n = 0;
        logic [DW-1:0] first = '0, mx = '0, mn = '1, sm = '0, an = '1, xr = '0;
        bit   same = 1'b1;
        for (int i = 0; i < NREQ; i++) begin
            if (v[i]) begin
                if (n == 0) first = d[i*DW +: DW];
                n++;
                if (d[i*DW +: DW] > mx) mx = d[i*DW +: DW];
                if (d[i*DW +: DW] < mn) mn = d[i*DW +: DW];
                sm = sm + d[i*DW +: DW];
                an = an & d[i*DW +: DW];
                xr = xr ^ d[i*DW +: DW];
            end
        end
        for (int i = 0; i < NREQ; i++)
            if (v[i] && d[i*DW +: DW] != first) same = 1'b0;
        e.tag = tag; e.offered = d; e.offv = v;
        e.col = (n > 1);
        e.we  = (n > 0) && !(m == 4'd2 && !same);
        e.dmode = 1;
        if (!e.we) begin
            e.word = model_word;
            if (!known) e.dmode = 0;
        end else if (n == 1) begin
            e.word = first; known = 1'b1;
        end else begin
            case (m)
                4'd0: begin e.dmode = 0; known = 1'b0; end
                4'd1: e.word = '1;
                4'd2: e.word = first;
                4'd3: begin e.dmode = 2; known = 1'b0; end
                4'd5: e.word = mx;
                4'd6: e.word = mn;
                4'd7: e.word = sm;
                4'd8: e.word = an;
                4'd9: e.word = xr;
                default: e.word = first;
            endcase
            if (e.dmode == 1) known = 1'b1;
        end
        if (e.dmode == 1) model_word = e.word;
        @(negedge clk);
        mode = m; valid = v; data = d;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // Monitor: at each falling edge compare registered outputs to the queue.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t e;
            bit   hit;
            e = q.pop_front();
            chk(wr_en_o == e.we, e.tag, "wr_en", {7'd0, wr_en_o}, {7'd0, e.we});
            chk(collide_o == e.col, e.col ? "R4" : e.tag, "collide",
                {7'd0, collide_o}, {7'd0, e.col});
            if (e.dmode == 1) chk(word_o === e.word, e.tag, "word", word_o, e.word);
            if (e.dmode == 2) begin
                hit = 1'b0;
                for (int i = 0; i < NREQ; i++)
                    if (e.offv[i] && e.offered[i*DW +: DW] == word_o) hit = 1'b1;
                chk(hit, e.tag, "word not from a valid lane", word_o, e.offered[DW-1:0]);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        valid = '1; data = pk(8'h12, 8'h34, 8'h56, 8'h78); mode = 4'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(word_o == '0 && !wr_en_o && !collide_o, "R1", "reset state",
            word_o, 8'h00);
        rst_n = 1'b1;
        valid = '0;
        drive(4'd4, 4'b0000, pk(8'h01, 8'h02, 8'h03, 8'h04), "R2");
        for (int m = 0; m < 10; m++) begin
            logic [NREQ*DW-1:0] d;
            d = {NREQ{8'hAA}};
            d[(m % NREQ)*DW +: DW] = 8'h10 + 8'(m);
            drive(4'(m), 4'(1 << (m % NREQ)), d, "R3");
        end
        drive(4'd4, 4'b1110, pk(8'h11, 8'h22, 8'h33, 8'h44), "R5");
        drive(4'd4, 4'b1001, pk(8'h11, 8'h22, 8'h33, 8'h44), "R5");
        drive(4'd12, 4'b1100, pk(8'h11, 8'h22, 8'h33, 8'h44), "R5");
        drive(4'd1, 4'b0011, pk(8'h11, 8'h22, 8'h33, 8'h44), "R6");
        drive(4'd1, 4'b1111, pk(8'h11, 8'h22, 8'h33, 8'h44), "R6");
        drive(4'd2, 4'b1011, pk(8'h5A, 8'h5A, 8'h77, 8'h5A), "R7");
        drive(4'd2, 4'b0111, pk(8'h5A, 8'h5A, 8'h77, 8'h5A), "R7");
        drive(4'd2, 4'b0000, pk(8'h00, 8'h00, 8'h00, 8'h00), "R2");
        for (int r = 0; r < 3; r++) begin
            drive(4'd3, 4'b1111, pk(8'h01, 8'h02, 8'h04, 8'h08), "R8");
            drive(4'd3, 4'b1010, pk(8'h01, 8'h02, 8'h04, 8'h08), "R8");
            drive(4'd3, 4'b0110, pk(8'h01, 8'h02, 8'h04, 8'h08), "R8");
            drive(4'd3, 4'b1001, pk(8'h01, 8'h02, 8'h04, 8'h08), "R8");
        end
        drive(4'd3, 4'b0100, pk(8'h00, 8'h00, 8'h66, 8'h00), "R3");
        drive(4'd5, 4'b1111, pk(8'hF0, 8'h0F, 8'h80, 8'h7F), "R9");
        drive(4'd6, 4'b1111, pk(8'hF0, 8'h0F, 8'h80, 8'h7F), "R9");
        drive(4'd5, 4'b0110, pk(8'hF0, 8'h0F, 8'h80, 8'h7F), "R9");
        drive(4'd6, 4'b1100, pk(8'hF0, 8'h0F, 8'h80, 8'h7F), "R9");
        drive(4'd7, 4'b1111, pk(8'hC0, 8'h50, 8'h10, 8'h01), "R10");
        drive(4'd8, 4'b0111, pk(8'hF3, 8'h3F, 8'hFF, 8'h00), "R11");
        drive(4'd9, 4'b0011, pk(8'hF3, 8'h3F, 8'hFF, 8'h00), "R11");
        drive(4'd0, 4'b0110, pk(8'h21, 8'h43, 8'h65, 8'h87), "R12");
        drive(4'd0, 4'b1000, pk(8'h21, 8'h43, 8'h65, 8'h87), "R3");
        drive(4'd9, 4'b0000, pk(8'h00, 8'h00, 8'h00, 8'h00), "R2");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule